// File: doc/BRIEF.md
# Standby Mode Clock Controller

This block decides when the CPU of a small 8-bit controller gets its clock and which oscillators stay powered. Software asks for one of two standby depths. The shallow depth (halt) gates only the CPU clock and leaves every oscillator as it was. The deep depth (stop) also powers down the high-speed oscillator, so the whole system stops. An enabled interrupt request ends either depth. Leaving halt gives the clock back on the next cycle. Leaving stop first passes through a stabilization wait, and the CPU clock stays off until that wait is over.

The length of that wait depends on which source clocks the CPU. If the internal oscillator clocks the CPU, the wait is a fixed count of internal-oscillator cycles (17 by default). If the high-speed oscillator clocks the CPU, the wait is a programmable count of high-speed cycles, taken from an input at the moment stop is entered. The controller runs on one always-on reference clock. The oscillators are seen as one-cycle strobes, one strobe per oscillator period.

Top module: `standby_clk_ctrl`

## Requirements
- R1: While reset is asserted, and on its release, `mode` is 0, `cpu_clk_en` is 1 and `hs_osc_en` is 1.
- R2: `mode` encodes run = 0, halt = 1, stop = 2 and stabilization wait = 3. `cpu_clk_en` is 1 exactly when `mode` is 0.
- R3: In run, a `halt_req` without `stop_req` moves `mode` to 1 on the next clock edge. During halt, `hs_osc_en` stays 1.
- R4: In run, a `stop_req` moves `mode` to 2 on the next clock edge. `hs_osc_en` is 0 for exactly as long as `mode` is 2.
- R5: If `halt_req` and `stop_req` are both high in run, the block enters stop (mode 2).
- R6: In halt, any bit set in both `irq_req` and `irq_en` returns `mode` to 0 on the next edge. A request whose enable bit is 0 has no effect.
- R7: In stop, an enabled interrupt moves `mode` to 3 on the next edge, and `cpu_clk_en` stays 0.
- R8: If `cpu_src_io` was 1 at stop entry, the wait counts `io_tick` strobes and ignores `hs_tick`. `mode` becomes 0 one edge after the edge that takes in the 17th strobe.
- R9: If `cpu_src_io` was 0 at stop entry, the wait counts `hs_tick` strobes up to the `stab_cnt` value sampled at stop entry. Later changes to `stab_cnt` have no effect. A value of 0 gives one cycle in mode 3.
- R10: A halt or stop request made while an enabled interrupt is already pending still enters that mode. The block leaves the mode on the following edge.
- R11: `halt_req` and `stop_req` are ignored when `mode` is not 0.
- R12: In every mode, `io_osc_en` equals `io_keep` OR `cpu_src_io`, so the internal oscillator never stops during stop if it was running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_req | input | 1 | Request to enter the shallow standby |
| stop_req | input | 1 | Request to enter the deep standby |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Per-line wake enable |
| cpu_src_io | input | 1 | 1 when the internal oscillator clocks the CPU |
| io_keep | input | 1 | Software wants the internal oscillator running |
| stab_cnt | input | CNT_W | High-speed stabilization count, sampled at stop entry |
| hs_tick | input | 1 | One strobe per high-speed oscillator cycle |
| io_tick | input | 1 | One strobe per internal oscillator cycle |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| hs_osc_en | output | 1 | High-speed oscillator enable |
| io_osc_en | output | 1 | Internal oscillator enable |
| mode | output | 2 | Current mode code |

## Verification
The assertions check these on every cycle: the clock gate agrees with the mode code, stop wins over halt, each wake-up takes the correct next mode, the high-speed oscillator is off only in stop, and the wait never ends before its counter finishes. Some behaviour only the bench's scenarios can show: the exact length of the wait for each clock source, that a `stab_cnt` value written after stop entry is ignored, that strobes from the wrong oscillator are ignored, and that a request made with an interrupt already pending bounces through the mode in one cycle.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_HALT = 2'd1,
    MODE_STOP = 2'd2,
    MODE_WAIT = 2'd3
  } mode_e;

  // Next-mode rule; stop outranks halt when both are requested in run.
  function automatic mode_e next_mode(input mode_e cur, input logic halt,
                                      input logic stop, input logic wake,
                                      input logic done);
    mode_e nxt;
    nxt = cur;
    unique case (cur)
      MODE_RUN:  if (stop) nxt = MODE_STOP;
                 else if (halt) nxt = MODE_HALT;
      MODE_HALT: if (wake) nxt = MODE_RUN;
      MODE_STOP: if (wake) nxt = MODE_WAIT;
      MODE_WAIT: if (done) nxt = MODE_RUN;
      default:   nxt = MODE_RUN;
    endcase
    return nxt;
  endfunction

  // Oscillator enables as a function of mode.
  function automatic logic hs_enable(input mode_e cur);
    return cur != MODE_STOP;
  endfunction

  function automatic logic io_enable(input logic keep, input logic src_io);
    return keep | src_io;
  endfunction

endpackage

// File: rtl/stby_wake.sv
module stby_wake #(
  parameter int N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  output logic             wake
);
  logic [N_IRQ-1:0] hit;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    assign hit[i] = irq_req[i] & irq_en[i];
  end

  assign wake = |hit;
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  halt_req,
  input  logic  stop_req,
  input  logic  wake,
  input  logic  wait_done,
  output mode_e mode_q,
  output logic  stop_enter,
  output logic  wait_active
);
  mode_e mode_d;

  always_comb begin
    mode_d = next_mode(mode_q, halt_req, stop_req, wake, wait_done);
  end

  assign stop_enter  = (mode_q == MODE_RUN) && stop_req;
  assign wait_active = (mode_q == MODE_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_RUN;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/stby_wait_ctr.sv
module stby_wait_ctr #(
  parameter int CNT_W   = 8,
  parameter int IO_WAIT = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             src_io,
  input  logic [CNT_W-1:0] prog_cnt,
  input  logic             active,
  input  logic             hs_tick,
  input  logic             io_tick,
  output logic             done
);
  // CNT_W must be wide enough to hold IO_WAIT.
  localparam logic [CNT_W-1:0] IO_LOAD = CNT_W'(IO_WAIT);

  logic [CNT_W-1:0] cnt_q;
  logic             src_io_q;
  logic             tick_sel;

  assign tick_sel = src_io_q ? io_tick : hs_tick;
  assign done     = active && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      src_io_q <= 1'b0;
    end else if (load) begin
      cnt_q    <= src_io ? IO_LOAD : prog_cnt;
      src_io_q <= src_io;
    end else if (active && tick_sel && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/stby_osc_ctl.sv
module stby_osc_ctl
  import stby_pkg::*;
(
  input  mode_e mode_q,
  input  logic  io_keep,
  input  logic  cpu_src_io,
  output logic  cpu_clk_en,
  output logic  hs_osc_en,
  output logic  io_osc_en
);
  assign cpu_clk_en = (mode_q == MODE_RUN);
  assign hs_osc_en  = hs_enable(mode_q);
  assign io_osc_en  = io_enable(io_keep, cpu_src_io);
endmodule

// File: rtl/standby_clk_ctrl.sv
module standby_clk_ctrl
  import stby_pkg::*;
#(
  parameter int N_IRQ   = 8,
  parameter int CNT_W   = 8,
  parameter int IO_WAIT = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req,
  input  logic             stop_req,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             cpu_src_io,
  input  logic             io_keep,
  input  logic [CNT_W-1:0] stab_cnt,
  input  logic             hs_tick,
  input  logic             io_tick,
  output logic             cpu_clk_en,
  output logic             hs_osc_en,
  output logic             io_osc_en,
  output logic [1:0]       mode
);
  // Internal events, named for the checker.
  logic  wake;
  logic  wait_done;
  logic  stop_enter;
  logic  wait_active;
  mode_e mode_q;

  stby_wake #(.N_IRQ(N_IRQ)) u_wake (
    .irq_req (irq_req),
    .irq_en  (irq_en),
    .wake    (wake)
  );

  stby_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_req    (halt_req),
    .stop_req    (stop_req),
    .wake        (wake),
    .wait_done   (wait_done),
    .mode_q      (mode_q),
    .stop_enter  (stop_enter),
    .wait_active (wait_active)
  );

  stby_wait_ctr #(.CNT_W(CNT_W), .IO_WAIT(IO_WAIT)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (stop_enter),
    .src_io   (cpu_src_io),
    .prog_cnt (stab_cnt),
    .active   (wait_active),
    .hs_tick  (hs_tick),
    .io_tick  (io_tick),
    .done     (wait_done)
  );

  stby_osc_ctl u_osc (
    .mode_q     (mode_q),
    .io_keep    (io_keep),
    .cpu_src_io (cpu_src_io),
    .cpu_clk_en (cpu_clk_en),
    .hs_osc_en  (hs_osc_en),
    .io_osc_en  (io_osc_en)
  );

  assign mode = mode_q;
endmodule

// File: rtl/stby_chk.sv
module stby_chk
  import stby_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       halt_req,
  input logic       stop_req,
  input logic       cpu_src_io,
  input logic       wake,
  input logic       wait_done,
  input logic [1:0] mode,
  input logic       cpu_clk_en,
  input logic       hs_osc_en,
  input logic       io_osc_en
);
  assert_clk_only_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en == (mode == MODE_RUN));

  assert_halt_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RUN && halt_req && !stop_req) |=> (mode == MODE_HALT));

  assert_hs_off_in_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hs_osc_en == (mode != MODE_STOP));

  assert_stop_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RUN && stop_req) |=> (mode == MODE_STOP));

  assert_halt_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HALT && wake) |=> (mode == MODE_RUN));

  assert_stop_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STOP && wake) |=> (mode == MODE_WAIT));

  assert_wait_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WAIT && !wait_done) |=> (mode == MODE_WAIT));

  assert_stop_no_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STOP && !wake) |=> (mode == MODE_STOP));

  assert_io_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_src_io |-> io_osc_en);
endmodule

bind standby_clk_ctrl stby_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .halt_req   (halt_req),
  .stop_req   (stop_req),
  .cpu_src_io (cpu_src_io),
  .wake       (wake),
  .wait_done  (wait_done),
  .mode       (mode),
  .cpu_clk_en (cpu_clk_en),
  .hs_osc_en  (hs_osc_en),
  .io_osc_en  (io_osc_en)
);

// File: tb/sim_standby_clk_ctrl.sv
`timescale 1ns/1ps
module sim_standby_clk_ctrl;
  localparam int N_IRQ = 8;
  localparam int CNT_W = 8;
  localparam int IO_CYC = 17;

  logic clk = 1'b0;
  logic rst_n, halt_req, stop_req, cpu_src_io, io_keep, hs_tick, io_tick;
  logic [N_IRQ-1:0] irq_req, irq_en;
  logic [CNT_W-1:0] stab_cnt;
  logic cpu_clk_en, hs_osc_en, io_osc_en;
  logic [1:0] mode;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  standby_clk_ctrl #(.N_IRQ(N_IRQ), .CNT_W(CNT_W), .IO_WAIT(IO_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req),
    .irq_req(irq_req), .irq_en(irq_en), .cpu_src_io(cpu_src_io),
    .io_keep(io_keep), .stab_cnt(stab_cnt), .hs_tick(hs_tick),
    .io_tick(io_tick), .cpu_clk_en(cpu_clk_en), .hs_osc_en(hs_osc_en),
    .io_osc_en(io_osc_en), .mode(mode)
  );

  // Row layout: [9]halt [8]stop [7]irq0 [6]src_io [5]keep |
  //             [4:3]mode [2]cpu_clk_en [1]hs_osc_en [0]io_osc_en
  localparam int NV = 19;
  localparam logic [9:0] VEC [NV] = '{
    10'b1_0_0_0_0_01_0_1_0,  // halt              R3
    10'b0_0_0_0_0_01_0_1_0,  // stay halted
    10'b0_0_1_0_0_00_1_1_0,  // irq wakes halt    R6
    10'b0_1_0_0_0_10_0_0_0,  // stop              R4
    10'b1_0_0_0_0_10_0_0_0,  // halt in stop      R11
    10'b0_0_1_0_0_11_0_1_0,  // irq -> wait       R7
    10'b0_0_0_0_0_00_1_1_0,  // count 0 -> run    R9
    10'b1_1_0_0_0_10_0_0_0,  // both -> stop      R5
    10'b0_0_1_0_0_11_0_1_0,  // irq -> wait
    10'b0_0_0_0_0_00_1_1_0,  // run
    10'b1_0_1_0_0_01_0_1_0,  // halt w/ pending   R10
    10'b0_0_1_0_0_00_1_1_0,  // bounces out
    10'b0_0_0_0_1_00_1_1_1,  // keep io osc       R12
    10'b0_1_0_0_1_10_0_0_1,  // stop keeps io osc
    10'b0_0_1_0_1_11_0_1_1,
    10'b0_0_0_0_1_00_1_1_1,
    10'b0_1_1_0_0_10_0_0_0,  // stop w/ pending   R10
    10'b0_0_1_0_0_11_0_1_0,  // out next edge
    10'b0_0_0_0_0_00_1_1_0
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_mode(input string req, input int exp);
    check(mode == 2'(exp), req, "mode", int'(mode), exp);
    check(cpu_clk_en == (exp == 0), req, "cpu_clk_en", int'(cpu_clk_en), int'(exp == 0));
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    halt_req = 0; stop_req = 0; irq_req = '0; hs_tick = 0; io_tick = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog all-requirements actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(); cpu_src_io = 0; io_keep = 0; irq_en = '1; stab_cnt = '0;
    cyc(); cyc();
    // R1 reset state
    check(mode == 2'd0, "R1", "mode in reset", int'(mode), 0);
    check(cpu_clk_en == 1'b1, "R1", "cpu_clk_en in reset", int'(cpu_clk_en), 1);
    check(hs_osc_en == 1'b1, "R1", "hs_osc_en in reset", int'(hs_osc_en), 1);
    rst_n = 1;
    cyc();
    chk_mode("R1", 0);

    // Table walk: covers R2 R3 R4 R5 R6 R7 R9 R10 R11 R12
    for (int i = 0; i < NV; i++) begin
      halt_req = VEC[i][9]; stop_req = VEC[i][8]; irq_req = {7'd0, VEC[i][7]};
      cpu_src_io = VEC[i][6]; io_keep = VEC[i][5];
      cyc();
      check(mode == VEC[i][4:3], "R2", $sformatf("row %0d mode", i), int'(mode), int'(VEC[i][4:3]));
      check(cpu_clk_en == VEC[i][2], "R2", $sformatf("row %0d cpu_clk_en", i), int'(cpu_clk_en), int'(VEC[i][2]));
      check(hs_osc_en == VEC[i][1], "R4", $sformatf("row %0d hs_osc_en", i), int'(hs_osc_en), int'(VEC[i][1]));
      check(io_osc_en == VEC[i][0], "R12", $sformatf("row %0d io_osc_en", i), int'(io_osc_en), int'(VEC[i][0]));
    end
    idle(); io_keep = 0; cpu_src_io = 0;
    cyc();

    // R6: a disabled interrupt does not wake halt
    halt_req = 1; cyc(); idle();
    irq_en = 8'hFE; irq_req = 8'h01; cyc(); cyc();
    chk_mode("R6", 1);
    irq_req = 8'h80; cyc();
    chk_mode("R6", 0);
    idle(); irq_en = '1; cyc();

    // R8: internal-oscillator source, 17 io strobes, hs strobes ignored
    cpu_src_io = 1; stop_req = 1; cyc(); idle();
    chk_mode("R8", 2);
    check(io_osc_en == 1'b1, "R12", "io_osc_en in stop", int'(io_osc_en), 1);
    irq_req = 8'h04; cyc(); idle();
    chk_mode("R8", 3);
    hs_tick = 1;
    for (int k = 0; k < 30; k++) cyc();
    chk_mode("R8", 3);
    hs_tick = 0; io_tick = 1;
    for (int k = 0; k < IO_CYC; k++) cyc();
    chk_mode("R8", 3);
    cyc();
    chk_mode("R8", 0);
    idle(); cpu_src_io = 0; cyc();

    // R9: high-speed source, count sampled at entry, later writes ignored
    stab_cnt = 8'd5; stop_req = 1; cyc(); idle();
    stab_cnt = 8'd200;
    irq_req = 8'h10; cyc(); idle();
    chk_mode("R9", 3);
    for (int k = 0; k < 9; k++) begin
      hs_tick = (k % 2 == 0);
      cyc();
      chk_mode("R9", 3);
    end
    hs_tick = 0; cyc();
    chk_mode("R9", 0);

    // R11: stop request during halt is ignored
    halt_req = 1; cyc(); idle();
    stop_req = 1; cyc();
    chk_mode("R11", 1);
    check(hs_osc_en == 1'b1, "R3", "hs_osc_en in halt", int'(hs_osc_en), 1);
    idle(); irq_req = 8'h02; cyc(); idle();
    chk_mode("R11", 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule